// File: doc/BRIEF.md
# MSDU Release List Splitter

This block takes one release command describing a list of MSDU buffers and turns it into a sequence of per-MSDU completion records, one for each list entry, emitted in list order. A command header arrives first on its own valid/ready channel. It carries the owning buffer manager ID, the number of entries, a list-release flag, a flag saying the release came from a direct software remove, and the RSSI of the acknowledging frame. The entries then arrive on a second valid/ready channel. Each entry carries a buffer address, a software cookie, three notify bits and a 19-bit buffer timestamp.

Each output record repeats the entry's address and cookie and the command's manager ID and RSSI. It also carries a details-valid bit with first-of-list and last-of-list markers. The details bit is raised only when the command is a list release and its owner is a manager other than the local one (parameter `LOCAL_RBM`). In every other case the markers, notify bits and timestamp are zeroed. A transfer happens on a channel in any cycle where valid and ready are both high. A record that has been offered stays unchanged until it is taken. While the output is stalled, no entry is accepted.

Top module: `msdu_list_splitter`

## Requirements
- R1: Each accepted entry yields exactly one record. Records leave in entry order, and each record carries that entry's address and cookie plus the command's manager ID.
- R2: `rec_details` is 1 exactly when the command had `hdr_list`=1 and `hdr_rbm` differs from `LOCAL_RBM`.
- R3: When details are valid, `rec_first` is 1 on the record of the first entry of the list and 0 on every other record.
- R4: When details are valid, `rec_last` is 1 on the record of the final entry and 0 on the others. A one-entry list has both markers set.
- R5: When details are valid, `rec_notify` (3 bits) and `rec_tstamp` (19 bits) equal the entry's values unchanged.
- R6: When details are not valid, `rec_first`, `rec_last`, `rec_notify` and `rec_tstamp` are all 0.
- R7: `rec_rssi` is 8'h00 when the command had `hdr_sw_remove`=1. Otherwise it is `hdr_rssi`.
- R8: While `rec_valid`=1 and `rec_ready`=0, the record stays unchanged in the next cycle and `ent_ready` is 0.
- R9: A header with `hdr_count`=0 is accepted in the cycle it is offered, produces no record, and leaves `hdr_ready` at 1.
- R10: After a header with a non-zero count is accepted, `hdr_ready` stays 0 until the cycle after the last record of that list is accepted. `ent_ready` is 0 whenever `hdr_ready` is 1.
- R11: After reset, `rec_valid`=0, `ent_ready`=0 and `hdr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Command header offered |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_rbm | input | RBM_W | Owning buffer manager ID |
| hdr_count | input | CNT_W | Number of entries in the list |
| hdr_list | input | 1 | Command is a list release |
| hdr_sw_remove | input | 1 | Release caused by a direct software remove |
| hdr_rssi | input | 8 | RSSI of the acknowledging frame |
| ent_valid | input | 1 | List entry offered |
| ent_ready | output | 1 | Entry can be accepted |
| ent_addr | input | ADDR_W | Buffer address |
| ent_cookie | input | COOKIE_W | Software buffer cookie |
| ent_notify | input | 3 | Notify bits |
| ent_tstamp | input | 19 | Buffer timestamp |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Downstream takes the record |
| rec_addr | output | ADDR_W | Buffer address |
| rec_cookie | output | COOKIE_W | Software buffer cookie |
| rec_rbm | output | RBM_W | Owning manager ID |
| rec_rssi | output | 8 | RSSI, or zero for software removes |
| rec_first | output | 1 | First record of the list |
| rec_last | output | 1 | Last record of the list |
| rec_details | output | 1 | Release details valid |
| rec_notify | output | 3 | Notify bits |
| rec_tstamp | output | 19 | Buffer timestamp |

## Verification
The properties assume that the downstream side may hold `rec_ready` low for any length of time, and that the upstream side keeps header and entry fields steady while it waits. The properties also assume that a header's count matches the number of entries that follow it. The stimulus always sends exactly `hdr_count` entries after each header, and it changes fields only after a transfer. The stimulus mixes full-rate acceptance with a repeating stall pattern, including a long stall held over the first record of a list.

// File: rtl/msdu_split_pkg.sv
`timescale 1ns/1ps
package msdu_split_pkg;
  localparam int RSSI_W = 8;
  localparam int NOTE_W = 3;
  localparam int TS_W   = 19;

  typedef struct packed {
    logic              list_rel;
    logic              sw_remove;
    logic [RSSI_W-1:0] rssi;
  } cmd_attr_t;
endpackage

// File: rtl/msdu_split_ctrl.sv
`timescale 1ns/1ps
module msdu_split_ctrl
  import msdu_split_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RBM_W     = 4,
  parameter int LOCAL_RBM = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [CNT_W-1:0] hdr_count,
  input  logic [RBM_W-1:0] hdr_rbm,
  input  cmd_attr_t        hdr_attr,
  input  logic             ent_valid,
  input  logic             slot_free,
  input  logic             drain_end,
  output logic             hdr_ready,
  output logic             ent_ready,
  output logic             ent_take,
  output logic             cur_first,
  output logic             cur_last,
  output logic             cur_details,
  output logic [RBM_W-1:0] cur_rbm,
  output cmd_attr_t        cur_attr
);
  localparam logic [RBM_W-1:0] LOC = RBM_W'(LOCAL_RBM);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy_q, tail_q, first_q, det_q;
  logic [CNT_W-1:0] left_q;
  logic [RBM_W-1:0] rbm_q;
  cmd_attr_t        attr_q;
  logic             hdr_take;

  assign hdr_ready = !busy_q;
  assign hdr_take  = hdr_valid && hdr_ready;
  assign ent_ready = busy_q && !tail_q && slot_free;
  assign ent_take  = ent_ready && ent_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tail_q  <= 1'b0;
      first_q <= 1'b0;
      det_q   <= 1'b0;
      left_q  <= '0;
      rbm_q   <= '0;
      attr_q  <= '0;
    end else begin
      if (hdr_take && hdr_count != '0) begin
        busy_q  <= 1'b1;
        tail_q  <= 1'b0;
        first_q <= 1'b1;
        left_q  <= hdr_count;
        rbm_q   <= hdr_rbm;
        attr_q  <= hdr_attr;
        det_q   <= hdr_attr.list_rel && (hdr_rbm != LOC);
      end else if (ent_take) begin
        left_q  <= left_q - ONE;
        first_q <= 1'b0;
        if (left_q == ONE) tail_q <= 1'b1;
      end else if (drain_end) begin
        busy_q <= 1'b0;
        tail_q <= 1'b0;
      end
    end
  end

  assign cur_first   = first_q;
  assign cur_last    = (left_q == ONE);
  assign cur_details = det_q;
  assign cur_rbm     = rbm_q;
  assign cur_attr    = attr_q;
endmodule

// File: rtl/msdu_split_fmt.sv
`timescale 1ns/1ps
module msdu_split_fmt
  import msdu_split_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int COOKIE_W = 20,
  parameter int RBM_W    = 4
) (
  input  logic [ADDR_W-1:0]   ent_addr,
  input  logic [COOKIE_W-1:0] ent_cookie,
  input  logic [NOTE_W-1:0]   ent_notify,
  input  logic [TS_W-1:0]     ent_tstamp,
  input  logic                cur_first,
  input  logic                cur_last,
  input  logic                cur_details,
  input  logic [RBM_W-1:0]    cur_rbm,
  input  cmd_attr_t           cur_attr,
  output logic [ADDR_W-1:0]   f_addr,
  output logic [COOKIE_W-1:0] f_cookie,
  output logic [RBM_W-1:0]    f_rbm,
  output logic [RSSI_W-1:0]   f_rssi,
  output logic                f_first,
  output logic                f_last,
  output logic                f_details,
  output logic [NOTE_W-1:0]   f_notify,
  output logic [TS_W-1:0]     f_tstamp
);
  always_comb begin
    f_addr    = ent_addr;
    f_cookie  = ent_cookie;
    f_rbm     = cur_rbm;
    f_rssi    = cur_attr.sw_remove ? '0 : cur_attr.rssi;
    f_details = cur_details;
    f_first   = cur_details & cur_first;
    f_last    = cur_details & cur_last;
    f_notify  = cur_details ? ent_notify : '0;
    f_tstamp  = cur_details ? ent_tstamp : '0;
  end
endmodule

// File: rtl/msdu_split_oreg.sv
`timescale 1ns/1ps
module msdu_split_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_in,
  input  logic         end_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] d_out,
  output logic         slot_free,
  output logic         drain_end
);
  logic end_q;

  assign slot_free = !out_valid || out_ready;
  assign drain_end = out_valid && out_ready && end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      end_q     <= 1'b0;
      d_out     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      end_q     <= end_in;
      d_out     <= d_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      end_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/msdu_list_splitter.sv
`timescale 1ns/1ps
module msdu_list_splitter
  import msdu_split_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int COOKIE_W  = 20,
  parameter int RBM_W     = 4,
  parameter int CNT_W     = 8,
  parameter int LOCAL_RBM = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_valid,
  output logic                hdr_ready,
  input  logic [RBM_W-1:0]    hdr_rbm,
  input  logic [CNT_W-1:0]    hdr_count,
  input  logic                hdr_list,
  input  logic                hdr_sw_remove,
  input  logic [7:0]          hdr_rssi,
  input  logic                ent_valid,
  output logic                ent_ready,
  input  logic [ADDR_W-1:0]   ent_addr,
  input  logic [COOKIE_W-1:0] ent_cookie,
  input  logic [2:0]          ent_notify,
  input  logic [18:0]         ent_tstamp,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [ADDR_W-1:0]   rec_addr,
  output logic [COOKIE_W-1:0] rec_cookie,
  output logic [RBM_W-1:0]    rec_rbm,
  output logic [7:0]          rec_rssi,
  output logic                rec_first,
  output logic                rec_last,
  output logic                rec_details,
  output logic [2:0]          rec_notify,
  output logic [18:0]         rec_tstamp
);
  localparam int REC_W = ADDR_W + COOKIE_W + RBM_W + RSSI_W + 3 + NOTE_W + TS_W;

  cmd_attr_t        h_attr, c_attr;
  logic             ent_take, slot_free, drain_end;
  logic             c_first, c_last, c_det;
  logic [RBM_W-1:0] c_rbm;

  logic [ADDR_W-1:0]   f_addr;
  logic [COOKIE_W-1:0] f_cookie;
  logic [RBM_W-1:0]    f_rbm;
  logic [RSSI_W-1:0]   f_rssi;
  logic                f_first, f_last, f_det;
  logic [NOTE_W-1:0]   f_notify;
  logic [TS_W-1:0]     f_ts;
  logic [REC_W-1:0]    rec_d, rec_q;

  assign h_attr = '{list_rel: hdr_list, sw_remove: hdr_sw_remove, rssi: hdr_rssi};

  msdu_split_ctrl #(.CNT_W(CNT_W), .RBM_W(RBM_W), .LOCAL_RBM(LOCAL_RBM)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_count(hdr_count), .hdr_rbm(hdr_rbm), .hdr_attr(h_attr),
    .ent_valid(ent_valid), .slot_free(slot_free), .drain_end(drain_end),
    .hdr_ready(hdr_ready), .ent_ready(ent_ready), .ent_take(ent_take),
    .cur_first(c_first), .cur_last(c_last), .cur_details(c_det),
    .cur_rbm(c_rbm), .cur_attr(c_attr)
  );

  msdu_split_fmt #(.ADDR_W(ADDR_W), .COOKIE_W(COOKIE_W), .RBM_W(RBM_W)) u_fmt (
    .ent_addr(ent_addr), .ent_cookie(ent_cookie), .ent_notify(ent_notify),
    .ent_tstamp(ent_tstamp), .cur_first(c_first), .cur_last(c_last),
    .cur_details(c_det), .cur_rbm(c_rbm), .cur_attr(c_attr),
    .f_addr(f_addr), .f_cookie(f_cookie), .f_rbm(f_rbm), .f_rssi(f_rssi),
    .f_first(f_first), .f_last(f_last), .f_details(f_det),
    .f_notify(f_notify), .f_tstamp(f_ts)
  );

  assign rec_d = {f_addr, f_cookie, f_rbm, f_rssi, f_first, f_last, f_det, f_notify, f_ts};

  msdu_split_oreg #(.W(REC_W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(ent_take), .d_in(rec_d), .end_in(c_last),
    .out_ready(rec_ready), .out_valid(rec_valid), .d_out(rec_q),
    .slot_free(slot_free), .drain_end(drain_end)
  );

  assign {rec_addr, rec_cookie, rec_rbm, rec_rssi, rec_first, rec_last,
          rec_details, rec_notify, rec_tstamp} = rec_q;
endmodule

// File: rtl/msdu_list_splitter_chk.sv
`timescale 1ns/1ps
module msdu_list_splitter_chk #(
  parameter int ADDR_W   = 64,
  parameter int COOKIE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hdr_ready,
  input logic                ent_ready,
  input logic                rec_valid,
  input logic                rec_ready,
  input logic [ADDR_W-1:0]   rec_addr,
  input logic [COOKIE_W-1:0] rec_cookie,
  input logic                rec_first,
  input logic                rec_last,
  input logic                rec_details,
  input logic [2:0]          rec_notify,
  input logic [18:0]         rec_tstamp
);
  AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_cookie) && $stable(rec_last)); // R8
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |-> !ent_ready); // R8
  AST_PLAIN_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_details |-> !rec_first && !rec_last && rec_notify == 3'd0 && rec_tstamp == 19'd0); // R6
  AST_HDR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !hdr_ready); // R10
  AST_IDLE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> !ent_ready); // R10
  AST_MARK_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_first |-> rec_details); // R3
endmodule

bind msdu_list_splitter msdu_list_splitter_chk #(.ADDR_W(ADDR_W), .COOKIE_W(COOKIE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_ready(hdr_ready), .ent_ready(ent_ready),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr),
  .rec_cookie(rec_cookie), .rec_first(rec_first), .rec_last(rec_last),
  .rec_details(rec_details), .rec_notify(rec_notify), .rec_tstamp(rec_tstamp)
);

// File: tb/test_msdu_list_splitter.sv
`timescale 1ns/1ps
module test_msdu_list_splitter;
  localparam int LOC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 0, hdr_list = 0, hdr_sw_remove = 0;
  logic [3:0] hdr_rbm = 0;
  logic [7:0] hdr_count = 0, hdr_rssi = 0;
  logic ent_valid = 0;
  logic [63:0] ent_addr = 0;
  logic [19:0] ent_cookie = 0;
  logic [2:0] ent_notify = 0;
  logic [18:0] ent_tstamp = 0;
  logic rec_ready = 0;
  logic hdr_ready, ent_ready, rec_valid, rec_first, rec_last, rec_details;
  logic [63:0] rec_addr;
  logic [19:0] rec_cookie;
  logic [3:0] rec_rbm;
  logic [7:0] rec_rssi;
  logic [2:0] rec_notify;
  logic [18:0] rec_tstamp;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msdu_list_splitter #(.LOCAL_RBM(LOC)) i_msdu_list_splitter (.*);

  // {count, list, rbm, sw_remove, rssi, stall}
  localparam logic [22:0] VEC [6] = '{
    {8'd4, 1'b1, 4'd5,  1'b0, 8'h9A, 1'b0},
    {8'd1, 1'b1, 4'd1,  1'b1, 8'h77, 1'b0},
    {8'd3, 1'b1, 4'd3,  1'b0, 8'h40, 1'b1},
    {8'd5, 1'b0, 4'd7,  1'b0, 8'hC3, 1'b1},
    {8'd6, 1'b1, 4'd15, 1'b1, 8'h11, 1'b1},
    {8'd2, 1'b1, 4'd0,  1'b0, 8'hFF, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] e_addr(int row, int i);
    return 64'h1000_0000_0000_0000 + 64'(row * 256 + i);
  endfunction
  function automatic logic [19:0] e_cookie(int row, int i); return 20'(row * 16 + i + 5); endfunction
  function automatic logic [2:0]  e_note(int row, int i);   return 3'((row + i) % 8); endfunction
  function automatic logic [18:0] e_ts(int row, int i);     return 19'(row * 1000 + i * 7 + 1); endfunction

  task automatic send_cmd(input int row, input logic [7:0] cnt, input bit lst,
                          input logic [3:0] rbm, input bit swr, input logic [7:0] rssi);
    @(negedge clk);
    hdr_valid = 1; hdr_count = cnt; hdr_list = lst; hdr_rbm = rbm;
    hdr_sw_remove = swr; hdr_rssi = rssi;
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 0;
    for (int i = 0; i < cnt; i++) begin
      if (i > 0) @(negedge clk);
      ent_valid = 1; ent_addr = e_addr(row, i); ent_cookie = e_cookie(row, i);
      ent_notify = e_note(row, i); ent_tstamp = e_ts(row, i);
      #1;
      while (!ent_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    ent_valid = 0;
  endtask

  task automatic recv_list(input int row, input int cnt, input bit lst, input logic [3:0] rbm,
                           input bit swr, input logic [7:0] rssi, input bit stall);
    bit det;
    int k = 0, cyc = 0;
    det = lst && (rbm != 4'(LOC));
    while (k < cnt) begin
      @(negedge clk);
      rec_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
      #1;
      if (rec_valid && rec_ready) begin
        chk(rec_addr == e_addr(row, k), "R1 addr", rec_addr, e_addr(row, k));
        chk(rec_cookie == e_cookie(row, k), "R1 cookie", 64'(rec_cookie), 64'(e_cookie(row, k)));
        chk(rec_rbm == rbm, "R1 rbm", 64'(rec_rbm), 64'(rbm));
        chk(rec_details == det, "R2 details", 64'(rec_details), 64'(det));
        chk(rec_first == (det && k == 0), "R3 first", 64'(rec_first), 64'(det && k == 0));
        chk(rec_last == (det && k == cnt - 1), "R4 last", 64'(rec_last), 64'(det && k == cnt - 1));
        if (det) begin
          chk(rec_notify == e_note(row, k), "R5 notify", 64'(rec_notify), 64'(e_note(row, k)));
          chk(rec_tstamp == e_ts(row, k), "R5 tstamp", 64'(rec_tstamp), 64'(e_ts(row, k)));
        end else begin
          chk(rec_notify == 0 && rec_tstamp == 0, "R6 zeroed",
              64'({rec_notify, rec_tstamp}), 64'(0));
        end
        chk(rec_rssi == (swr ? 8'h00 : rssi), "R7 rssi", 64'(rec_rssi), 64'(swr ? 8'h00 : rssi));
        chk(!hdr_ready, "R10 hdr held", 64'(hdr_ready), 64'(0));
        k++;
      end
    end
    @(negedge clk);
    #1;
    chk(hdr_ready, "R10 hdr released", 64'(hdr_ready), 64'(1));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!rec_valid, "R11 rec_valid", 64'(rec_valid), 64'(0));
    chk(hdr_ready, "R11 hdr_ready", 64'(hdr_ready), 64'(1));
    chk(!ent_ready, "R11 ent_ready", 64'(ent_ready), 64'(0));
    @(negedge clk);
    rst_n = 1;

    for (int r = 0; r < 6; r++) begin
      logic [22:0] v;
      v = VEC[r];
      fork
        send_cmd(r, v[22:15], v[14], v[13:10], v[9], v[8:1]);
        recv_list(r, int'(v[22:15]), v[14], v[13:10], v[9], v[8:1], v[0]);
      join
    end

    // R9: zero-length list
    @(negedge clk);
    rec_ready = 1;
    hdr_valid = 1; hdr_count = 0; hdr_list = 1; hdr_rbm = 5;
    #1;
    chk(hdr_ready, "R9 zero count accepted", 64'(hdr_ready), 64'(1));
    @(negedge clk);
    hdr_valid = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #1;
      chk(!rec_valid && hdr_ready && !ent_ready, "R9 no record",
          64'({rec_valid, hdr_ready, ent_ready}), 64'(3'b010));
    end

    // R8: long stall over the first record
    fork
      send_cmd(7, 8'd2, 1'b1, 4'd9, 1'b0, 8'h55);
      begin
        rec_ready = 0;
        repeat (6) @(negedge clk);
        #1;
        chk(rec_valid, "R8 held valid", 64'(rec_valid), 64'(1));
        chk(rec_addr == e_addr(7, 0), "R8 held addr", rec_addr, e_addr(7, 0));
        chk(!ent_ready, "R8 no entry taken", 64'(ent_ready), 64'(0));
        chk(rec_first, "R8 held first", 64'(rec_first), 64'(1));
        recv_list(7, 2, 1'b1, 4'd9, 1'b0, 8'h55, 1'b0);
      end
    join

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule